// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register Interface

This block is the digital front end of a segmented, current-steering DAC with a parallel data input. A data word reaches the converter through two storage stages. The first is an input register, gated by an active-low write strobe. The second is a DAC register, gated by an active-high load strobe. Several converters can share a data bus, each be written in turn, and then be updated together by a single load. A clear pin empties both stages at once. The value it clears to is zero or midscale, chosen by a select pin.

All external pins are assumed asynchronous to the system clock. The block brings them onto that clock through synchronizer flops, and delays the data bus by the same number of stages. The level-sensitive (transparent) behaviour of the strobes is then rebuilt from flops, with no latches. The DAC register drives a segment decoder. Its top four bits become fifteen equally weighted thermometer enables. Its remaining low bits pass unchanged to the binary ladder switches, as a coarse group and a four-bit fine group. For checking, the block also reports the ideal bipolar output code. A parameter selects the 16-bit build or the 14-bit build.

Top module: `pdac_frontend`

## Requirements
- R1: While the synchronized write strobe `wr_n` is low, the input register takes the data bus on every clock. While `wr_n` is high, the input register holds its value.
- R2: While the synchronized `load` is high, the DAC register takes the input register's next value. While `load` is low, the DAC register holds its value.
- R3: With `wr_n` low and `load` high, both registers are transparent, and the data bus reaches `dac_code`. A pin change is visible at the register outputs on the third rising clock edge after it.
- R4: With `wr_n` high and `load` low, neither register changes.
- R5: While `clr_n` is low, both registers are forced to the clear value, whatever the strobes are doing. The clear value is 0 when `mid_sel` is 0, and midscale (only the top bit set, 0x8000 at 16 bits) when `mid_sel` is 1. The system reset `rst_n` loads the same value, picked by the `mid_sel` pin.
- R6: When `wr_n` and `load` are driven as a single pulse (both low, then both high), the data present while the pulse is low is captured. That word reaches `dac_code`, and data presented while the pulse is high is ignored.
- R7: `seg_en[i]` is 1 exactly when the top four bits of the DAC register, read as an unsigned value M, satisfy M > i. The number of asserted enables therefore equals M.
- R8: `ladder_fine` equals DAC register bits [3:0]. `ladder_coarse` equals the bits from 4 up to the bit below the segment field (bits [11:4] at 16 bits).
- R9: `dac_code` is the ideal unipolar magnitude D, in steps of Vref/2^N. `bip_code` is D − 2^(N−1) as an N-bit two's complement value: code 0 gives the most negative value, and midscale gives 0.
- R10: A change of `mid_sel` while `clr_n` is high has no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| data_in | input | RES_W | Parallel data bus pins |
| wr_n | input | 1 | Active-low write strobe pin, gates the input register |
| load | input | 1 | Active-high load pin, gates the DAC register |
| clr_n | input | 1 | Active-low clear pin for both registers |
| mid_sel | input | 1 | Clear value select: 0 gives zero, 1 gives midscale |
| dac_code | output | RES_W | DAC register contents, the ideal unipolar code |
| bip_code | output | RES_W | Ideal bipolar code, two's complement |
| seg_en | output | 15 | Thermometer segment enables for the top four bits |
| ladder_coarse | output | RES_W-8 | Upper binary ladder switch group |
| ladder_fine | output | 4 | Lower binary ladder switch group |

## Verification
On every cycle, the assertions check the hold cases of both registers, the clear value and the thermometer shape and count of the segment enables, all on the synchronized strobe levels. Only the bench's scenarios can show that a written word really arrives at the DAC output and with what latency. The same holds for the pulse with both strobes tied together, a clear that lands in the middle of a write, and a select-pin toggle that leaves the stored data untouched. The bench also sweeps every value of the segment field and sends random strobe mixes against its own model.

// File: rtl/pdac_pkg.sv
// Package: shared types for the parallel DAC front end.
// Assumes strobe levels have already been synchronized to the system clock.
package pdac_pkg;

    // What the two register stages do for one strobe combination
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,   // write high, load low
        ACT_WRITE   = 2'd1,   // write low, load low
        ACT_LOAD    = 2'd2,   // write high, load high
        ACT_PASS    = 2'd3    // write low, load high: transparent
    } stage_act_t;

    // Synchronized control pin levels
    typedef struct packed {
        logic mid_sel;
        logic clr_n;
        logic load;
        logic wr_n;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{mid_sel: 1'b0, clr_n: 1'b1, load: 1'b0, wr_n: 1'b1};

    // Map strobe levels onto a stage action
    function automatic stage_act_t decode_act(input logic wr_n, input logic load);
        case ({load, wr_n})
            2'b00:   return ACT_WRITE;
            2'b01:   return ACT_HOLD;
            2'b10:   return ACT_PASS;
            default: return ACT_LOAD;
        endcase
    endfunction

endpackage

// File: rtl/pdac_sync.sv
// Module: pdac_sync
// Multi-stage flop chain that brings asynchronous pins onto clk.
// Assumes a multi-bit bus is stable around strobe activity, so that the
// bits of a bus never need to be captured coherently while they toggle.
module pdac_sync #(
    parameter int           WIDTH   = 1,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the pin levels through the chain each clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pdac_regs.sv
// Module: pdac_regs
// Input register and DAC register with level-gated behaviour rebuilt in
// flops. Clear has priority over both strobes.
// Assumes all inputs except por_sel are synchronous to clk.
module pdac_regs
    import pdac_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_sel,
    input  logic [RES_W-1:0] din,
    input  ctrl_t            ctrl,
    output logic [RES_W-1:0] in_q,
    output logic [RES_W-1:0] dac_q
);

    localparam logic [RES_W-1:0] MID_VAL = RES_W'(1) << (RES_W - 1);

    stage_act_t       act;
    logic [RES_W-1:0] in_nxt;
    logic [RES_W-1:0] clr_val;
    logic [RES_W-1:0] por_val;

    // Decode strobes and form the transparent next input value
    always_comb begin
        act     = decode_act(ctrl.wr_n, ctrl.load);
        in_nxt  = (act == ACT_WRITE || act == ACT_PASS) ? din : in_q;
        clr_val = ctrl.mid_sel ? MID_VAL : '0;
        por_val = por_sel ? MID_VAL : '0;
    end

    // Update the input register
    always_ff @(posedge clk) begin
        if (!rst_n)          in_q <= por_val;
        else if (!ctrl.clr_n) in_q <= clr_val;
        else                 in_q <= in_nxt;
    end

    // Update the DAC register
    always_ff @(posedge clk) begin
        if (!rst_n)                                 dac_q <= por_val;
        else if (!ctrl.clr_n)                       dac_q <= clr_val;
        else if (act == ACT_LOAD || act == ACT_PASS) dac_q <= in_nxt;
    end

endmodule

// File: rtl/pdac_seg_decode.sv
// Module: pdac_seg_decode
// Splits a DAC code into thermometer segment enables for the top bits and
// binary ladder drives (coarse and fine) for the rest.
// Assumes RES_W > SEG_BITS + FINE_W.
module pdac_seg_decode #(
    parameter int RES_W    = 16,
    parameter int SEG_BITS = 4,
    parameter int FINE_W   = 4
) (
    input  logic [RES_W-1:0]                       code,
    output logic [(1<<SEG_BITS)-2:0]               seg_en,
    output logic [RES_W-SEG_BITS-FINE_W-1:0]       coarse,
    output logic [FINE_W-1:0]                      fine
);

    localparam int LSB_W     = RES_W - SEG_BITS;
    localparam int SEG_LINES = (1 << SEG_BITS) - 1;

    logic [SEG_BITS-1:0] seg_val;
    assign seg_val = code[RES_W-1 -: SEG_BITS];

    // One comparator per segment line: line i is on when the field exceeds i
    for (genvar i = 0; i < SEG_LINES; i++) begin : g_seg
        assign seg_en[i] = (seg_val > SEG_BITS'(i));
    end

    // Binary pass-through to the ladder switch groups
    assign coarse = code[LSB_W-1:FINE_W];
    assign fine   = code[FINE_W-1:0];

endmodule

// File: rtl/pdac_frontend.sv
// Module: pdac_frontend (top)
// Double-buffered parallel DAC register interface: synchronizes the pins,
// holds the input and DAC registers and drives the segment decoder.
// Assumes the data bus settles before the write strobe rises.
module pdac_frontend
    import pdac_pkg::*;
#(
    parameter int RES_W    = 16,
    parameter int SEG_BITS = 4,
    parameter int FINE_W   = 4,
    parameter int SYNC_N   = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [RES_W-1:0]                     data_in,
    input  logic                                 wr_n,
    input  logic                                 load,
    input  logic                                 clr_n,
    input  logic                                 mid_sel,
    output logic [RES_W-1:0]                     dac_code,
    output logic [RES_W-1:0]                     bip_code,
    output logic [(1<<SEG_BITS)-2:0]             seg_en,
    output logic [RES_W-SEG_BITS-FINE_W-1:0]     ladder_coarse,
    output logic [FINE_W-1:0]                    ladder_fine
);

    localparam logic [RES_W-1:0] MID_VAL = RES_W'(1) << (RES_W - 1);

    ctrl_t            ctrl_pin;
    ctrl_t            ctrl_s;
    logic [RES_W-1:0] din_s;
    logic [RES_W-1:0] in_q;
    logic [RES_W-1:0] dac_q;
    logic             wr_s, ld_s, clr_s, sel_s;

    assign ctrl_pin = '{mid_sel: mid_sel, clr_n: clr_n, load: load, wr_n: wr_n};

    // Control pin synchronizer
    pdac_sync #(.WIDTH(4), .STAGES(SYNC_N), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
        .clk(clk), .rst_n(rst_n), .d(ctrl_pin), .q(ctrl_s)
    );

    // Data bus delay matched to the control path
    pdac_sync #(.WIDTH(RES_W), .STAGES(SYNC_N), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d(data_in), .q(din_s)
    );

    assign wr_s  = ctrl_s.wr_n;
    assign ld_s  = ctrl_s.load;
    assign clr_s = ctrl_s.clr_n;
    assign sel_s = ctrl_s.mid_sel;

    // Two register stages
    pdac_regs #(.RES_W(RES_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .por_sel(mid_sel), .din(din_s),
        .ctrl(ctrl_s), .in_q(in_q), .dac_q(dac_q)
    );

    // Segment and ladder decode
    pdac_seg_decode #(.RES_W(RES_W), .SEG_BITS(SEG_BITS), .FINE_W(FINE_W)) u_dec (
        .code(dac_q), .seg_en(seg_en), .coarse(ladder_coarse), .fine(ladder_fine)
    );

    // Ideal output codes
    assign dac_code = dac_q;
    assign bip_code = dac_q - MID_VAL;

endmodule

// File: rtl/pdac_frontend_chk.sv
// Module: pdac_frontend_chk
// Assertion checker bound to pdac_frontend; observes synchronized strobes,
// both register stages and the segment enables.
module pdac_frontend_chk #(
    parameter int RES_W    = 16,
    parameter int SEG_BITS = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_s,
    input logic                     ld_s,
    input logic                     clr_s,
    input logic                     sel_s,
    input logic [RES_W-1:0]         in_q,
    input logic [RES_W-1:0]         dac_q,
    input logic [(1<<SEG_BITS)-2:0] seg_en
);

    localparam logic [RES_W-1:0] MID_VAL = RES_W'(1) << (RES_W - 1);

    AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_s && clr_s) |=> $stable(in_q)); // R1

    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_s && clr_s) |=> $stable(dac_q)); // R2

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_s && !ld_s && clr_s) |=> ($stable(in_q) && $stable(dac_q))); // R4

    AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> ((dac_q == ($past(sel_s) ? MID_VAL : '0)) &&
                    (in_q  == ($past(sel_s) ? MID_VAL : '0)))); // R5

    AST_SEG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seg_en) == int'(dac_q[RES_W-1 -: SEG_BITS])); // R7

    AST_SEG_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_en >> 1) & ~seg_en) == '0); // R7

endmodule

bind pdac_frontend pdac_frontend_chk #(.RES_W(RES_W), .SEG_BITS(SEG_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_s(wr_s), .ld_s(ld_s), .clr_s(clr_s),
    .sel_s(sel_s), .in_q(in_q), .dac_q(dac_q), .seg_en(seg_en)
);

// File: tb/pdac_frontend_tb.sv
`timescale 1ns/1ps
module pdac_frontend_tb;

    localparam int RES_W  = 16;
    localparam int SEG_B  = 4;
    localparam int FINE_W = 4;
    localparam int LSB_W  = RES_W - SEG_B;
    localparam int LINES  = (1 << SEG_B) - 1;
    localparam logic [RES_W-1:0] MID = RES_W'(1) << (RES_W - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [RES_W-1:0] data_in = '0;
    logic wr_n = 1'b1, load = 1'b0, clr_n = 1'b1, mid_sel = 1'b0;
    logic [RES_W-1:0] dac_code, bip_code;
    logic [LINES-1:0] seg_en;
    logic [LSB_W-FINE_W-1:0] ladder_coarse;
    logic [FINE_W-1:0] ladder_fine;

    int n_chk = 0, n_bad = 0;
    logic [RES_W-1:0] m_in = '0, m_dac = '0;

    always #2.5 clk = ~clk;

    pdac_frontend #(.RES_W(RES_W), .SEG_BITS(SEG_B), .FINE_W(FINE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .wr_n(wr_n), .load(load),
        .clr_n(clr_n), .mid_sel(mid_sel), .dac_code(dac_code), .bip_code(bip_code),
        .seg_en(seg_en), .ladder_coarse(ladder_coarse), .ladder_fine(ladder_fine)
    );

    function automatic logic [LINES-1:0] exp_seg(input logic [RES_W-1:0] d);
        logic [LINES-1:0] r = '0;
        for (int i = 0; i < LINES; i++) r[i] = (int'(d[RES_W-1 -: SEG_B]) > i);
        return r;
    endfunction

    function automatic logic [RES_W-1:0] exp_bip(input logic [RES_W-1:0] d);
        return RES_W'(int'(d) - (1 << (RES_W - 1)));
    endfunction

    task automatic check(input string req, input string what,
                         input logic [RES_W-1:0] act, input logic [RES_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Full output comparison against the model's DAC register
    task automatic check_all(input string req);
        check(req, "dac_code", dac_code, m_dac);
        check("R9", "bip_code", bip_code, exp_bip(m_dac));
        check("R7", "seg_en", RES_W'(seg_en), RES_W'(exp_seg(m_dac)));
        check("R8", "ladder", RES_W'({ladder_coarse, ladder_fine}), RES_W'(m_dac[LSB_W-1:0]));
    endtask

    // Apply pins, update the model with the level rules, wait past latency
    task automatic apply(input logic [RES_W-1:0] d, input logic w, input logic l,
                         input logic c, input logic s);
        logic [RES_W-1:0] nxt;
        data_in = d; wr_n = w; load = l; clr_n = c; mid_sel = s;
        if (!c) begin
            m_in = s ? MID : '0; m_dac = m_in;
        end else begin
            nxt = w ? m_in : d;
            m_in = nxt;
            if (l) m_dac = nxt;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        check_all("R5");                        // reset state: zero
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 transparent pass and latency: visible after exactly three edges
        data_in = 16'hA5C3; wr_n = 1'b0; load = 1'b1;
        repeat (2) @(posedge clk); #1;
        check("R3", "before 3rd edge", dac_code, 16'h0000);
        @(posedge clk); #1;
        check("R3", "after 3rd edge", dac_code, 16'hA5C3);
        m_in = 16'hA5C3; m_dac = 16'hA5C3;
        apply(16'hA5C3, 1'b0, 1'b1, 1'b1, 1'b0);
        check_all("R3");

        // R1/R2 write without load, then hold, then load
        apply(16'h1234, 1'b0, 1'b0, 1'b1, 1'b0);
        check_all("R2");                        // DAC still A5C3
        apply(16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0);
        check_all("R4");
        apply(16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0);
        check_all("R1");                        // input held 1234

        // R6 tied pulse
        apply(16'h7E01, 1'b0, 1'b0, 1'b1, 1'b0);
        apply(16'h0BAD, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R6", "tied pulse", dac_code, 16'h7E01);

        // R5 clear during a transparent write, midscale select
        apply(16'h3333, 1'b0, 1'b1, 1'b0, 1'b1);
        check_all("R5");
        apply(16'h3333, 1'b0, 1'b1, 1'b1, 1'b1);
        check_all("R5");                        // released: bus passes again
        apply(16'h4444, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all("R5");                        // clear to zero

        // R10 select toggles without clear
        apply(16'h9876, 1'b0, 1'b1, 1'b1, 1'b0);
        apply(16'h0000, 1'b1, 1'b0, 1'b1, 1'b1);
        check_all("R10");
        apply(16'h0000, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R10", "input reg after sel toggle", dac_code, 16'h9876);

        // R7/R8/R9 every segment value
        for (int m = 0; m < 16; m++) begin
            apply({4'(m), 12'($urandom)}, 1'b0, 1'b1, 1'b1, 1'b0);
            check_all("R7");
        end

        // Random strobe mixes
        for (int k = 0; k < 300; k++) begin
            apply(16'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom % 8) != 0, 1'($urandom));
            check_all("R1");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule